// File: doc/BRIEF.md
# Access Cycle Wait-State Timer

This block prices and paces a single bus access on a 24-bit address space. When an access starts, it classifies the address into a speed region using the bank (bits 23:16) and the page (bits 15:8). It then turns that region into a cost in master-clock cycles. A DMA access always takes the short fixed cost. A CPU access takes a fast, slow or extra-slow cost. In one part of the map, a fast-ROM enable bit chooses between the fast and the slow cost.

The cost is paid out in two-master-clock steps, one step per clock cycle. Each step advances a free-running 64-bit master-clock counter by two. A step that leaves the counter on a multiple of four also raises a one-cycle tick enable for the video unit. The surrounding bus logic pulses `start_i` while the timer is idle. It then waits for `done_o` before it completes the data transfer.

Top module: `acc_wait_timer`

## Requirements
- R1: After reset, `mclk_o` is 0 and `busy_o`, `step_o`, `done_o` and `vid_tick_o` are all low.
- R2: A CPU access to any bank from 0x40 to 0x7F costs 8 master clocks, whatever the fast-ROM bit says.
- R3: A CPU access to any bank from 0xC0 to 0xFF costs 6 master clocks when the fast-ROM bit is 1, and 8 when it is 0.
- R4: In banks 0x00–0x3F and 0x80–0xBF, a CPU access with page (address bits 15:8) in 0x00–0x1F costs 8. Pages 0x20–0x3F cost 6, pages 0x40–0x41 cost 12, pages 0x42–0x5F cost 6 and pages 0x60–0x7F cost 8.
- R5: A CPU access with page 0x80–0xFF costs 8 in banks 0x00–0x3F. In banks 0x80–0xBF it costs 6 with the fast-ROM bit at 1 and 8 with it at 0.
- R6: An access with `dma_i` = 1 costs 4 master clocks at any address.
- R7: A start accepted at a clock edge raises `busy_o` from the next cycle for cost/2 consecutive cycles. `step_o` is high in exactly those cycles, and each step adds 2 to `mclk_o`, which otherwise holds.
- R8: `vid_tick_o` is high in exactly those step cycles after which `mclk_o` is a multiple of 4.
- R9: `done_o` is high for the one cycle that follows the last step, with `busy_o` low. A start pulse while `busy_o` is high is ignored, and the running access keeps its length.
- R10: The fast-ROM bit is taken at the accepted start. Changing it during the access leaves the cost unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an access (taken only when idle) |
| addr_i | input | 24 | Access address: bank in 23:16, page in 15:8 |
| dma_i | input | 1 | 1 = DMA access, 0 = CPU access |
| fast_rom_i | input | 1 | Fast-ROM enable |
| busy_o | output | 1 | An access is being paced |
| step_o | output | 1 | A two-clock step is taken this cycle |
| done_o | output | 1 | One-cycle pulse after the final step |
| vid_tick_o | output | 1 | Video-unit tick enable |
| mclk_o | output | 64 | Running master-clock count |

## Verification
The address patterns probe every boundary of the region map. They include the first and last page of each page band in a low bank and in a mirrored bank, the edge banks 0x3F/0x40, 0x7F and 0x80/0xBF/0xC0, and the upper-page half with the fast-ROM bit in both states. Together these separate a wrong bank split from a wrong page split and from an inverted fast-ROM selection. DMA accesses go to addresses that would otherwise cost 12 or 8, so a DMA path that falls through to the region map is exposed. Two further patterns cover the remaining behaviour. Toggling the fast-ROM bit or pulsing start in the middle of an access tells a bit sampled at the start apart from one read live. Back-to-back starts issued in the done cycle show whether the counter and tick phase carry correctly across accesses.

// File: rtl/acc_wait_pkg.sv
package acc_wait_pkg;

    localparam int unsigned ADDR_W     = 24;
    localparam int unsigned CNT_W      = 64;
    localparam int unsigned STEP_CLK   = 2;
    localparam int unsigned TICK_DIV   = 4;
    localparam int unsigned COST_FAST  = 6;
    localparam int unsigned COST_SLOW  = 8;
    localparam int unsigned COST_XSLOW = 12;
    localparam int unsigned COST_DMA   = 4;

    localparam int unsigned MAX_COST  = COST_XSLOW;
    localparam int unsigned MAX_STEPS = MAX_COST / STEP_CLK;
    localparam int unsigned STEP_W    = $clog2(MAX_STEPS + 1);

    typedef enum logic [1:0] {
        REG_FAST  = 2'd0,
        REG_SLOW  = 2'd1,
        REG_XSLOW = 2'd2,
        REG_DMA   = 2'd3
    } acc_region_e;

    typedef logic [STEP_W-1:0] step_cnt_t;

    typedef struct packed {
        logic      busy;
        step_cnt_t left;
        logic      done;
    } pacer_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } mclk_state_t;

    function automatic step_cnt_t cost_to_steps(input int unsigned cost);
        return step_cnt_t'(cost / STEP_CLK);
    endfunction

endpackage

// File: rtl/acc_cost_map.sv
module acc_cost_map
    import acc_wait_pkg::*;
#(
    parameter int unsigned AW         = ADDR_W,
    parameter int unsigned C_FAST     = COST_FAST,
    parameter int unsigned C_SLOW     = COST_SLOW,
    parameter int unsigned C_XSLOW    = COST_XSLOW,
    parameter int unsigned C_DMA      = COST_DMA
) (
    input  logic [AW-1:0] addr_i,
    input  logic          dma_i,
    input  logic          fast_i,
    output acc_region_e   region_o,
    output step_cnt_t     steps_o
);

    localparam int unsigned BANK_LSB = AW - 8;
    localparam int unsigned PAGE_LSB = AW - 16;

    localparam logic [7:0] PG_SLOW_A_HI = 8'h1F;
    localparam logic [7:0] PG_FAST_A_HI = 8'h3F;
    localparam logic [7:0] PG_XSLOW_HI  = 8'h41;
    localparam logic [7:0] PG_FAST_B_HI = 8'h5F;
    localparam logic [7:0] PG_SLOW_B_HI = 8'h7F;

    localparam step_cnt_t STEPS_FAST  = cost_to_steps(C_FAST);
    localparam step_cnt_t STEPS_SLOW  = cost_to_steps(C_SLOW);
    localparam step_cnt_t STEPS_XSLOW = cost_to_steps(C_XSLOW);
    localparam step_cnt_t STEPS_DMA   = cost_to_steps(C_DMA);

    logic [7:0] bank;
    logic [7:0] page;
    logic       unused_low_bits;

    assign bank = addr_i[BANK_LSB +: 8];
    assign page = addr_i[PAGE_LSB +: 8];
    assign unused_low_bits = ^addr_i[PAGE_LSB-1:0];

    // bank[6] set: banks 40-7F and C0-FF (whole-bank regions)
    // bank[7] set: upper half of the map, where fast-ROM applies
    logic whole_bank;
    logic upper_map;
    logic rom_page;

    assign whole_bank = bank[6];
    assign upper_map  = bank[7];
    assign rom_page   = page[7];

    always_comb begin
        region_o = REG_SLOW;
        if (dma_i) begin
            region_o = REG_DMA;
        end else if (whole_bank) begin
            region_o = (upper_map && fast_i) ? REG_FAST : REG_SLOW;
        end else if (rom_page) begin
            region_o = (upper_map && fast_i) ? REG_FAST : REG_SLOW;
        end else if (page <= PG_SLOW_A_HI) begin
            region_o = REG_SLOW;
        end else if (page <= PG_FAST_A_HI) begin
            region_o = REG_FAST;
        end else if (page <= PG_XSLOW_HI) begin
            region_o = REG_XSLOW;
        end else if (page <= PG_FAST_B_HI) begin
            region_o = REG_FAST;
        end else if (page <= PG_SLOW_B_HI) begin
            region_o = REG_SLOW;
        end
    end

    always_comb begin
        unique case (region_o)
            REG_FAST:  steps_o = STEPS_FAST;
            REG_SLOW:  steps_o = STEPS_SLOW;
            REG_XSLOW: steps_o = STEPS_XSLOW;
            REG_DMA:   steps_o = STEPS_DMA;
            default:   steps_o = STEPS_SLOW;
        endcase
    end

endmodule

// File: rtl/acc_step_pacer.sv
module acc_step_pacer
    import acc_wait_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  step_cnt_t steps_i,
    output logic      busy_o,
    output logic      step_o,
    output logic      done_o
);

    pacer_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.left == step_cnt_t'(1)) begin
                st_d.busy = 1'b0;
                st_d.left = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.left = st_q.left - step_cnt_t'(1);
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.left = steps_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign step_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/acc_mclk_counter.sv
module acc_mclk_counter
    import acc_wait_pkg::*;
#(
    parameter int unsigned CW   = CNT_W,
    parameter int unsigned STEP = STEP_CLK,
    parameter int unsigned DIV  = TICK_DIV
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    output logic [CW-1:0] count_o,
    output logic          tick_o
);

    localparam int unsigned DIV_BITS = (DIV > 1) ? $clog2(DIV) : 1;

    mclk_state_t   st_d, st_q;
    logic [CW-1:0] after_step;
    logic          on_boundary;

    assign after_step = st_q.count + CW'(STEP);

    generate
        if ((DIV & (DIV - 1)) == 0) begin : g_pow2
            assign on_boundary = (after_step[DIV_BITS-1:0] == '0);
        end else begin : g_modulo
            assign on_boundary = ((after_step % CW'(DIV)) == '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.count = after_step;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign tick_o  = step_i && on_boundary;

endmodule

// File: rtl/acc_wait_timer.sv
module acc_wait_timer
    import acc_wait_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dma_i,
    input  logic              fast_rom_i,
    output logic              busy_o,
    output logic              step_o,
    output logic              done_o,
    output logic              vid_tick_o,
    output logic [CNT_W-1:0]  mclk_o
);

    acc_region_e region;
    step_cnt_t   steps;

    acc_cost_map #(
        .AW      (ADDR_W),
        .C_FAST  (COST_FAST),
        .C_SLOW  (COST_SLOW),
        .C_XSLOW (COST_XSLOW),
        .C_DMA   (COST_DMA)
    ) u_map (
        .addr_i   (addr_i),
        .dma_i    (dma_i),
        .fast_i   (fast_rom_i),
        .region_o (region),
        .steps_o  (steps)
    );

    logic unused_region;
    assign unused_region = ^region;

    acc_step_pacer u_pacer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .steps_i (steps),
        .busy_o  (busy_o),
        .step_o  (step_o),
        .done_o  (done_o)
    );

    acc_mclk_counter #(
        .CW   (CNT_W),
        .STEP (STEP_CLK),
        .DIV  (TICK_DIV)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step_o),
        .count_o (mclk_o),
        .tick_o  (vid_tick_o)
    );

endmodule

// File: rtl/acc_wait_checker.sv
module acc_wait_checker
    import acc_wait_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             dma_i,
    input logic             busy_o,
    input logic             step_o,
    input logic             done_o,
    input logic             vid_tick_o,
    input logic [CNT_W-1:0] mclk_o
);

    localparam int unsigned DMA_STEPS = COST_DMA / STEP_CLK;
    localparam int unsigned MIN_STEPS = COST_DMA / STEP_CLK;

    step_cnt_t run_q;
    logic      dma_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
            dma_q <= 1'b0;
        end else begin
            if (done_o) begin
                run_q <= '0;
            end else if (step_o) begin
                run_q <= run_q + step_cnt_t'(1);
            end
            if (start_i && !busy_o) begin
                dma_q <= dma_i;
            end
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (mclk_o == '0) && !busy_o && !done_o); // R1

    AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R7

    AST_MCLK_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> (mclk_o == $past(mclk_o) + CNT_W'(STEP_CLK))); // R7

    AST_MCLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_o |=> $stable(mclk_o)); // R7

    AST_TICK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vid_tick_o |=> (mclk_o % CNT_W'(TICK_DIV) == '0)); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && $past(busy_o)); // R9

    AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (run_q >= step_cnt_t'(MIN_STEPS)) && (run_q <= step_cnt_t'(MAX_STEPS))); // R4

    AST_DMA_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && dma_q) |-> (run_q == step_cnt_t'(DMA_STEPS))); // R6

endmodule

bind acc_wait_timer acc_wait_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dma_i      (dma_i),
    .busy_o     (busy_o),
    .step_o     (step_o),
    .done_o     (done_o),
    .vid_tick_o (vid_tick_o),
    .mclk_o     (mclk_o)
);

// File: tb/sim_acc_wait_timer.sv
`timescale 1ns/1ps
module sim_acc_wait_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic        dma = 1'b0;
    logic        fast = 1'b0;
    logic        busy, step, done, vtick;
    logic [63:0] mclk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_wait_timer u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .addr_i     (addr),
        .dma_i      (dma),
        .fast_rom_i (fast),
        .busy_o     (busy),
        .step_o     (step),
        .done_o     (done),
        .vid_tick_o (vtick),
        .mclk_o     (mclk)
    );

    typedef struct {
        int          cost;
        longint unsigned base;
        string       req;
    } exp_item_t;

    exp_item_t sb[$];
    int        run_steps = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cost(input logic [23:0] a, input bit d, input bit f);
        int b;
        int p;
        b = int'(a[23:16]);
        p = int'(a[15:8]);
        if (d) return 4;                          // R6
        if (b >= 'h40 && b <= 'h7F) return 8;     // R2
        if (b >= 'hC0) return f ? 6 : 8;          // R3
        if (p <= 'h1F) return 8;                  // R4
        if (p <= 'h3F) return 6;
        if (p <= 'h41) return 12;
        if (p <= 'h5F) return 6;
        if (p <= 'h7F) return 8;
        if (b <= 'h3F) return 8;                  // R5
        return f ? 6 : 8;
    endfunction

    // monitor: per-cycle step/tick checks and per-access scoreboard compare
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(step == busy, "R7", "step follows busy", step, busy);
            if (step) begin
                run_steps++;
                chk(vtick == (((mclk + 64'd2) % 64'd4) == 64'd0), "R8", "video tick",
                    vtick, (((mclk + 64'd2) % 64'd4) == 64'd0));
            end else begin
                chk(vtick == 1'b0, "R8", "tick outside step", vtick, 0);
            end
            if (done) begin
                chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_item_t it;
                    it = sb.pop_front();
                    chk(run_steps * 2 == it.cost, it.req, "step count x2",
                        run_steps * 2, it.cost);
                    chk(mclk - it.base == longint'(it.cost), it.req, "mclk delta",
                        longint'(mclk - it.base), it.cost);
                end
                run_steps = 0;
            end
        end
    end

    // driver: mode 0 plain, 1 flip fast-ROM mid access, 2 extra start mid access
    task automatic access(input logic [23:0] a, input bit d, input bit f,
                          input string req, input int mode);
        exp_item_t it;
        it.cost = exp_cost(a, d, f);
        it.base = mclk;
        it.req  = req;
        sb.push_back(it);
        addr  = a;
        dma   = d;
        fast  = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) begin
            fast = ~f;
            addr = 24'h004000;
        end
        if (mode == 2) begin
            @(negedge clk);
            start = 1'b1;
            addr  = 24'h001000;
            dma   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mclk == 64'd0, "R1", "mclk in reset", longint'(mclk), 0);
        chk({busy, step, done, vtick} == 4'b0, "R1", "flags in reset",
            {busy, step, done, vtick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mclk == 64'd0, "R1", "mclk after reset", longint'(mclk), 0);

        access(24'h451234, 0, 0, "R2", 0);
        access(24'h7FFFFF, 0, 1, "R2", 0);
        access(24'h400000, 0, 1, "R2", 0);
        access(24'hC00000, 0, 1, "R3", 0);
        access(24'hFF8000, 0, 0, "R3", 0);
        access(24'hE00010, 0, 1, "R3", 0);
        access(24'h001F00, 0, 1, "R4", 0);
        access(24'h002000, 0, 0, "R4", 0);
        access(24'h3F3FFF, 0, 0, "R4", 0);
        access(24'h004000, 0, 0, "R4", 0);
        access(24'h8041AB, 0, 1, "R4", 0);
        access(24'h004200, 0, 0, "R4", 0);
        access(24'h9F5F00, 0, 1, "R4", 0);
        access(24'h006000, 0, 1, "R4", 0);
        access(24'hBF7FFF, 0, 1, "R4", 0);
        access(24'h008000, 0, 1, "R5", 0);
        access(24'h3FFF00, 0, 0, "R5", 0);
        access(24'h808000, 0, 1, "R5", 0);
        access(24'hBFFFFF, 0, 0, "R5", 0);
        access(24'h004000, 1, 0, "R6", 0);
        access(24'h7E0000, 1, 1, "R6", 0);
        access(24'hC12345, 1, 0, "R6", 0);
        access(24'hC01234, 0, 1, "R10", 1);
        access(24'h808000, 0, 0, "R10", 1);
        access(24'h004100, 0, 0, "R9", 2);
        access(24'h2A2A2A, 0, 0, "R7", 0);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
        chk(busy == 1'b0, "R9", "idle at end", busy, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule